// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a logical address, a 16-bit selector plus a 32-bit offset, into a 32-bit linear address, checking the access along the way. It keeps six segment slots. Each slot has a selector and a hidden descriptor copy. The hidden copy is filled only when software writes a new selector into the slot.

A selector write starts a descriptor fetch through a simple read port. The fetch is two 32-bit reads, the low word first and then the high word. The table the fetch reads from is picked by the selector's table bit: either the global table (base and byte limit inputs) or the local table. The fetch reports its outcome as a load completion code.

Translation is combinational and reads only the hidden copies, so it never touches the read port. It adds the cached base to the offset. It checks for a null segment, privilege and the segment limit, and reports the result as a translation fault code.

Top module: `seg_xlate`

## Requirements
- R1: A selector holds the index in bits 15:3, the table bit in bit 2 (0 selects the global table, 1 the local table) and the requested privilege in bits 1:0. The fetch reads the low word at table base + index*8, then the high word at that address + 4.
- R2: An accepted load raises `busy` from the next cycle until the cycle in which `ld_done` pulses for one cycle. A load request made while `busy` is high is ignored.
- R3: A selector with index 0 and table bit 0 loads with no read and completes with code 00. Translating through that slot, or through slot number 6 or 7, gives code 01.
- R4: If index*8+7 is greater than the selected table's byte limit, the load completes with code 01. No read is made and the slot keeps its previous contents.
- R5: If the fetched high word has bit 15 (present) clear, the load completes with code 10 and the slot keeps its previous contents.
- R6: `xl_lin` equals the cached base plus `xl_off`. A translation makes no read.
- R7: The descriptor limit is {high[19:16], low[15:0]}. When the granularity bit (high bit 23) is 0 the limit counts bytes; when it is 1 the effective limit is (limit<<12)|0xFFF. An offset above the effective limit gives code 01.
- R8: The descriptor level is high[14:13]. The current level `cpl` is the requested level of the selector in slot 1. Translation gives code 11 when the larger of `cpl` and the slot's requested level is greater than the descriptor level.
- R9: Translation priority: a null segment (01) comes first, then a privilege fault (11), then a limit fault (01). Code 00 means the access is allowed.
- R10: After reset, every slot is null, `cpl` is 0, and `busy`, `rd_req` and `ld_done` are low.
- R11: The base is {high[31:24], high[7:0], low[31:16]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Request to write a selector |
| ld_seg | input | 3 | Slot to write (0-5; slot 1 is the code slot) |
| ld_sel | input | 16 | Selector value |
| gtbl_base | input | 32 | Global table base address |
| gtbl_lim | input | 16 | Global table byte limit |
| ltbl_base | input | 32 | Local table base address |
| ltbl_lim | input | 16 | Local table byte limit |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | 32 | Read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle load completion pulse |
| ld_code | output | 2 | Load result: 00 ok, 01 protection, 10 not present |
| xl_seg | input | 3 | Slot used for translation |
| xl_off | input | 32 | Offset |
| xl_lin | output | 32 | Linear address |
| xl_code | output | 2 | Translation result: 00 ok, 01 null or limit, 11 privilege |
| cpl | output | 2 | Current privilege level |

## Verification
The hardest case to reach is the one where a slot should keep its old descriptor: a load was refused, or a second request arrived in the middle of a fetch. From the ports these look the same as a load that succeeded with identical contents. To tell them apart, the stimulus first fills every slot with a distinct base and limit. Each refused load or mid-fetch request is then aimed at a slot whose old translation is known, and that translation is checked again afterwards. The privilege priority is reached by raising the code slot's level to 3 and then translating at an offset that also breaks the limit.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG    = 6,
  parameter int CS_SLOT = 1,
  parameter int SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SLOT_W-1:0] ld_seg,
  input  logic [15:0]       ld_sel,
  input  logic [31:0]       gtbl_base,
  input  logic [15:0]       gtbl_lim,
  input  logic [31:0]       ltbl_base,
  input  logic [15:0]       ltbl_lim,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  output logic              busy,
  output logic              ld_done,
  output logic [1:0]        ld_code,
  input  logic [SLOT_W-1:0] xl_seg,
  input  logic [31:0]       xl_off,
  output logic [31:0]       xl_lin,
  output logic [1:0]        xl_code,
  output logic [1:0]        cpl
);
  localparam int SLOTS = 1 << SLOT_W;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;
  st_t st;

  logic [SLOT_W-1:0] p_seg;
  logic [1:0]        p_rpl;
  logic [31:0]       p_addr, lo_q;

  logic [31:0] sh_base [SLOTS];
  logic [31:0] sh_elim [SLOTS];
  logic [1:0]  sh_dpl  [SLOTS];
  logic [1:0]  sh_rpl  [SLOTS];
  logic        sh_ok   [SLOTS];

  wire [12:0] idx     = ld_sel[15:3];
  wire        ti      = ld_sel[2];
  wire [31:0] tbase   = ti ? ltbl_base : gtbl_base;
  wire [15:0] tlim    = ti ? ltbl_lim : gtbl_lim;
  wire        is_null = (idx == 13'd0) && !ti;
  wire        over    = {idx, 3'b111} > tlim;
  wire        ld_slot = {1'b0, ld_seg} < (SLOT_W+1)'(NSEG);
  wire        xl_slot = {1'b0, xl_seg} < (SLOT_W+1)'(NSEG);

  wire [19:0] f_lim  = {rd_data[19:16], lo_q[15:0]};
  wire [31:0] f_base = {rd_data[31:24], rd_data[7:0], lo_q[31:16]};
  wire [31:0] f_elim = rd_data[23] ? {f_lim, 12'hFFF} : {12'h000, f_lim};

  assign busy    = (st != S_IDLE);
  assign rd_req  = busy;
  assign rd_addr = (st == S_HI) ? p_addr + 32'd4 : p_addr;
  assign cpl     = sh_rpl[CS_SLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ld_done <= 1'b0;
      ld_code <= 2'b00;
      p_seg   <= '0;
      p_rpl   <= 2'b00;
      p_addr  <= 32'd0;
      lo_q    <= 32'd0;
      for (int i = 0; i < SLOTS; i++) begin
        sh_base[i] <= 32'd0;
        sh_elim[i] <= 32'd0;
        sh_dpl[i]  <= 2'b00;
        sh_rpl[i]  <= 2'b00;
        sh_ok[i]   <= 1'b0;
      end
    end else begin
      ld_done <= 1'b0;
      case (st)
        S_IDLE: if (ld_en) begin
          if (!ld_slot || (!is_null && over)) begin
            ld_done <= 1'b1;
            ld_code <= 2'b01;
          end else if (is_null) begin
            sh_ok[ld_seg]  <= 1'b0;
            sh_rpl[ld_seg] <= ld_sel[1:0];
            ld_done        <= 1'b1;
            ld_code        <= 2'b00;
          end else begin
            st     <= S_LO;
            p_seg  <= ld_seg;
            p_rpl  <= ld_sel[1:0];
            p_addr <= tbase + {16'd0, idx, 3'b000};
          end
        end
        S_LO: if (rd_ack) begin
          lo_q <= rd_data;
          st   <= S_HI;
        end
        S_HI: if (rd_ack) begin
          st      <= S_IDLE;
          ld_done <= 1'b1;
          if (!rd_data[15]) ld_code <= 2'b10;
          else begin
            ld_code        <= 2'b00;
            sh_base[p_seg] <= f_base;
            sh_elim[p_seg] <= f_elim;
            sh_dpl[p_seg]  <= rd_data[14:13];
            sh_rpl[p_seg]  <= p_rpl;
            sh_ok[p_seg]   <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [1:0] x_rpl = sh_rpl[xl_seg];
  wire [1:0] eff   = (cpl > x_rpl) ? cpl : x_rpl;

  assign xl_lin  = sh_base[xl_seg] + xl_off;
  assign xl_code = (!xl_slot || !sh_ok[xl_seg]) ? 2'b01 :
                   (eff > sh_dpl[xl_seg])       ? 2'b11 :
                   (xl_off > sh_elim[xl_seg])   ? 2'b01 : 2'b00;

  // R1
  hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req) && $past(rd_ack)) |-> rd_addr == $past(rd_addr) + 32'd4);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_en));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> !ld_done);

  // R4
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && ld_code == 2'b01) |-> !$past(busy));

  // R8
  cpl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpl) |-> ld_done);
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, ld_en, rd_req, rd_ack, busy, ld_done;
  logic [2:0]  ld_seg, xl_seg;
  logic [15:0] ld_sel;
  logic [31:0] rd_addr, rd_data, xl_off, xl_lin;
  logic [1:0]  ld_code, xl_code, cpl;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .gtbl_base(32'h0002_0000), .gtbl_lim(16'h003F),
    .ltbl_base(32'h0003_0000), .ltbl_lim(16'h000F),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .ld_done(ld_done), .ld_code(ld_code),
    .xl_seg(xl_seg), .xl_off(xl_off), .xl_lin(xl_lin), .xl_code(xl_code), .cpl(cpl)
  );

  int ncmp = 0, nbad = 0, nreads = 0;
  logic [31:0] ra [2];
  logic [63:0] gd [8];
  logic [63:0] ldt [2];

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic g, input logic [1:0] d, input logic p);
    mk = {b[31:24], g, 3'b100, l[19:16], p, d, 1'b1, 4'h2, b[23:16], b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] memword(input logic [31:0] a);
    logic [63:0] w;
    w = 64'd0;
    if (a[31:16] == 16'h0002) w = gd[a[5:3]];
    else if (a[31:16] == 16'h0003) w = ldt[a[3]];
    memword = a[2] ? w[63:32] : w[31:0];
  endfunction

  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack  <= 1'b1;
      rd_data <= memword(rd_addr);
      ra[nreads % 2] <= rd_addr;
      nreads <= nreads + 1;
    end else rd_ack <= 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] s, input logic [15:0] sel, output logic [1:0] code);
    @(negedge clk);
    ld_en = 1'b1; ld_seg = s; ld_sel = sel;
    code = 2'bxx;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      ld_en = 1'b0;
      if (ld_done) begin code = ld_code; break; end
    end
  endtask

  task automatic xl(input logic [2:0] s, input logic [31:0] off, input string req,
                    input logic [31:0] elin, input logic [1:0] ecode, input logic cklin);
    @(negedge clk);
    xl_seg = s; xl_off = off;
    #1;
    if (cklin) check(req, xl_lin, elin);
    check(req, {30'd0, xl_code}, {30'd0, ecode});
  endtask

  localparam logic [68:0] VEC [11] = '{
    {3'd1, 32'h0000_1234, 32'h0000_1234, 2'b00},
    {3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00},
    {3'd3, 32'h0000_0FFF, 32'h1000_0FFF, 2'b00},
    {3'd3, 32'h0000_1000, 32'h1000_1000, 2'b01},
    {3'd0, 32'h0000_2FFF, 32'h0040_2FFF, 2'b00},
    {3'd0, 32'h0000_3000, 32'h0040_3000, 2'b01},
    {3'd2, 32'h0000_00FF, 32'h8000_00FF, 2'b00},
    {3'd4, 32'h0000_FFFF, 32'h0005_FFFF, 2'b00},
    {3'd4, 32'h0001_0000, 32'h0006_0000, 2'b01},
    {3'd5, 32'h0000_1FFF, 32'h7000_1FFF, 2'b00},
    {3'd5, 32'h0000_2000, 32'h7000_2000, 2'b01}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    logic [1:0] c;
    int n0;
    gd[0] = 64'd0;
    gd[1] = mk(32'h0000_0000, 20'hFFFFF, 1'b1, 2'd0, 1'b1);
    gd[2] = mk(32'h1000_0000, 20'h00FFF, 1'b0, 2'd3, 1'b1);
    gd[3] = mk(32'h0040_0000, 20'h00002, 1'b1, 2'd3, 1'b1);
    gd[4] = mk(32'h1234_5678, 20'h00010, 1'b0, 2'd0, 1'b0);
    gd[5] = mk(32'h8000_0000, 20'h000FF, 1'b0, 2'd2, 1'b1);
    gd[6] = 64'd0; gd[7] = 64'd0;
    ldt[0] = mk(32'h0005_0000, 20'h0FFFF, 1'b0, 2'd3, 1'b1);
    ldt[1] = mk(32'h7000_0000, 20'h00001, 1'b1, 2'd3, 1'b1);
    rst_n = 1'b0; ld_en = 1'b0; ld_seg = 3'd0; ld_sel = 16'd0;
    xl_seg = 3'd0; xl_off = 32'd0; rd_ack = 1'b0; rd_data = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 rd_req", {31'd0, rd_req}, 32'd0);
    check("R10 ld_done", {31'd0, ld_done}, 32'd0);
    check("R10 cpl", {30'd0, cpl}, 32'd0);
    xl(3'd2, 32'd0, "R10 null slot", 32'd0, 2'b01, 1'b0);

    // R1 fetch addresses, R2 busy
    n0 = nreads;
    @(negedge clk);
    ld_en = 1'b1; ld_seg = 3'd1; ld_sel = 16'h0008;
    @(negedge clk);
    ld_en = 1'b0;
    check("R2 busy after accept", {31'd0, busy}, 32'd1);
    c = 2'bxx;
    for (int k = 0; k < 50; k++) begin
      if (ld_done) begin c = ld_code; break; end
      @(negedge clk);
    end
    check("R2 busy low at done", {31'd0, busy}, 32'd0);
    check("R1 load code", {30'd0, c}, 32'd0);
    check("R1 read count", nreads - n0, 2);
    check("R1 low word addr", ra[n0 % 2], 32'h0002_0008);
    check("R1 high word addr", ra[(n0 + 1) % 2], 32'h0002_000C);

    do_load(3'd3, 16'h0013, c); check("R1 ds load", {30'd0, c}, 32'd0);
    do_load(3'd0, 16'h0018, c); check("R1 es load", {30'd0, c}, 32'd0);
    do_load(3'd2, 16'h0028, c); check("R1 ss load", {30'd0, c}, 32'd0);
    n0 = nreads;
    do_load(3'd4, 16'h0007, c); check("R1 local table load", {30'd0, c}, 32'd0);
    check("R1 local table addr", ra[(n0 + 1) % 2], 32'h0003_0004);
    do_load(3'd5, 16'h000F, c); check("R1 local idx1 load", {30'd0, c}, 32'd0);

    // R6 R7 R11 vector walk
    n0 = nreads;
    for (int v = 0; v < 11; v++)
      xl(VEC[v][68:66], VEC[v][65:34], "R6/R7/R11 vector", VEC[v][33:2], VEC[v][1:0], 1'b1);
    check("R6 no reads during translate", nreads - n0, 0);
    xl(3'd6, 32'd0, "R3 slot 6 null", 32'd0, 2'b01, 1'b0);

    // R5 not present keeps slot
    do_load(3'd3, 16'h0020, c); check("R5 not present code", {30'd0, c}, 32'd2);
    xl(3'd3, 32'h0000_0FFF, "R5 slot kept", 32'h1000_0FFF, 2'b00, 1'b1);

    // R4 index beyond limit
    n0 = nreads;
    do_load(3'd0, 16'h0040, c); check("R4 global beyond code", {30'd0, c}, 32'd1);
    do_load(3'd4, 16'h0014, c); check("R4 local beyond code", {30'd0, c}, 32'd1);
    check("R4 no reads", nreads - n0, 0);
    xl(3'd0, 32'h0000_2FFF, "R4 es kept", 32'h0040_2FFF, 2'b00, 1'b1);
    xl(3'd4, 32'h0000_FFFF, "R4 fs kept", 32'h0005_FFFF, 2'b00, 1'b1);

    // R2 request during busy ignored
    @(negedge clk);
    ld_en = 1'b1; ld_seg = 3'd3; ld_sel = 16'h0013;
    @(negedge clk);
    ld_seg = 3'd0; ld_sel = 16'h0028;
    @(negedge clk);
    ld_en = 1'b0;
    for (int k = 0; k < 50; k++) begin
      if (ld_done) break;
      @(negedge clk);
    end
    repeat (4) begin
      @(negedge clk);
      check("R2 no second done", {31'd0, ld_done}, 32'd0);
    end
    xl(3'd0, 32'h0000_2FFF, "R2 es untouched", 32'h0040_2FFF, 2'b00, 1'b1);

    // R3 null load
    n0 = nreads;
    do_load(3'd4, 16'h0003, c); check("R3 null code", {30'd0, c}, 32'd0);
    check("R3 no reads", nreads - n0, 0);
    xl(3'd4, 32'd0, "R3 null use", 32'd0, 2'b01, 1'b0);

    // R8 requested level weakens
    do_load(3'd2, 16'h002B, c);
    xl(3'd2, 32'h10, "R8 rpl above dpl", 32'h8000_0010, 2'b11, 1'b1);
    do_load(3'd2, 16'h0028, c);
    xl(3'd2, 32'h10, "R8 rpl restored", 32'h8000_0010, 2'b00, 1'b1);
    // R8 cpl from code slot
    do_load(3'd1, 16'h000B, c);
    check("R8 cpl", {30'd0, cpl}, 32'd3);
    xl(3'd1, 32'h0, "R8 cs dpl0 at cpl3", 32'h0, 2'b11, 1'b1);
    xl(3'd3, 32'h0, "R8 ds dpl3 at cpl3", 32'h1000_0000, 2'b00, 1'b1);
    // R9 privilege before limit, null before privilege
    xl(3'd2, 32'h100, "R9 priv over limit", 32'h8000_0100, 2'b11, 1'b1);
    xl(3'd4, 32'h0, "R9 null first", 32'h0, 2'b01, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule